// File: doc/BRIEF.md
# Transfer Count and Command Register Front End

This block holds the host-visible transfer count and command register of a storage bus controller. The host writes a 24-bit byte count as three byte-wide registers. It then writes a command byte. The top bit of the command byte selects DMA operation and copies the written count into a separate working counter. The low seven bits pick an operation, and the block reports that operation to the neighbouring sequencing blocks as a one-cycle strobe.

For a transfer-information command, the block works out the effective transfer length. This is the smaller of two values: the working count, where zero stands for 65536, and the size of the data still pending. While a command is being collected, the pending size is replaced by the size of the command buffer. The block also keeps the terminal-count status bit, the interrupt reason, the sequence step and the FIFO flag registers, a configuration register, and a chip identification readback.

Reads have no side effects. `rdata` follows `addr` combinationally.

Register addresses: 0 count low, 1 count middle, 2 count high, 3 command, 4 status, 5 interrupt reason, 6 sequence step, 7 FIFO flags, 8 configuration. Every other address reads zero and ignores writes.

Top module: `xfer_cmd_front`

## Requirements
- R1: After reset, addresses 0 and 1 read 0, address 2 reads CHIP_ID (default 0x5A), configuration (address 8) reads 7, and status, interrupt reason, sequence step and FIFO flags read 0. `dma_mode` and `op_stb` are 0.
- R2: Writes to addresses 0–2 update only the written copy of the count; addresses 0–2 read the working copy. The working copy changes only when a command byte with bit 7 set is written, and then it takes all three written bytes at once.
- R3: Every command write except a reset command sets `dma_mode` to bit 7 of the command byte.
- R4: A write to any of addresses 0–2 clears the terminal-count bit (status bit 4, read value 0x10). This clear wins over `tc_set` in the same cycle. `tc_set` alone sets the bit.
- R5: A transfer-information command (opcode 0x10) loads `xfer_len` with min(C, |pend_size|). C is the working count after any reload made by the same write, and a C of 0 counts as 65536. The new value appears one cycle after the write, together with strobe bit 3.
- R6: While `cmd_collect` is high, a transfer-information command loads `xfer_len` with min(C, CMD_BUF), where CMD_BUF defaults to 32.
- R7: A transfer-information command with bit 7 set clears the terminal-count bit. Without bit 7 it leaves the bit unchanged.
- R8: Address 2 reads CHIP_ID until address 2 has been written once after reset. After that it reads the working high byte.
- R9: A reset command (opcode 0x02) puts every register back into its R1 state, with configuration 7 and `dma_mode` 0.
- R10: A flush command (opcode 0x01) sets the interrupt reason to 0x08 and clears the sequence step and FIFO flags. It takes priority over `ev_load`.
- R11: Opcodes 0x00, 0x01, 0x02, 0x10, 0x11, 0x41 and 0x42 give strobe bits 0 through 6 respectively. The strobe is high for exactly one cycle, one cycle after the command write. Any other opcode raises no strobe and changes neither `xfer_len` nor the event registers.
- R12: `ev_load` loads the interrupt reason, sequence step and FIFO flags from `ev_intr`, `ev_seq` and `ev_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pend_size | input | 25 | Signed pending data size; the sign gives the direction |
| cmd_collect | input | 1 | A command is being collected |
| tc_set | input | 1 | Set the terminal-count status bit |
| ev_load | input | 1 | Load the event registers |
| ev_intr | input | 8 | Interrupt reason value to load |
| ev_seq | input | 8 | Sequence step value to load |
| ev_flags | input | 8 | FIFO flag value to load |
| dma_mode | output | 1 | DMA mode flag |
| xfer_len | output | 24 | Effective transfer length |
| op_stb | output | 7 | One-hot operation strobes |

## Verification
Every register update, `dma_mode`, `xfer_len` and the operation strobe change on the first clock edge after the write, so each of them is due one cycle after the stimulus. The bench drives on the falling edge. It checks strobes and `xfer_len` at the next falling edge, which is the only cycle in which a strobe is high. Register reads are combinational, so the bench sets `addr` on a falling edge and samples `rdata` a quarter period later, with no clock edge in between. The transfer-length sweep crosses eight counts with eight signed pending sizes. It runs both with and without command collection, and its expected values come from plain integer minimums.

// File: rtl/xfer_cmd_pkg.sv
// Shared constants for the transfer count / command front end.
// Assumes an 8-bit host data path and a 7-bit opcode field.
package xfer_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int OPC_W  = 7;

    // register addresses
    localparam logic [3:0] A_CNT_LO = 4'd0;
    localparam logic [3:0] A_CNT_MD = 4'd1;
    localparam logic [3:0] A_CNT_HI = 4'd2;
    localparam logic [3:0] A_CMD    = 4'd3;
    localparam logic [3:0] A_STAT   = 4'd4;
    localparam logic [3:0] A_INTR   = 4'd5;
    localparam logic [3:0] A_SEQ    = 4'd6;
    localparam logic [3:0] A_FLAGS  = 4'd7;
    localparam logic [3:0] A_CFG    = 4'd8;

    // opcodes
    localparam logic [OPC_W-1:0] OP_NOP    = 7'h00;
    localparam logic [OPC_W-1:0] OP_FLUSH  = 7'h01;
    localparam logic [OPC_W-1:0] OP_RESET  = 7'h02;
    localparam logic [OPC_W-1:0] OP_XFER   = 7'h10;
    localparam logic [OPC_W-1:0] OP_CMPL   = 7'h11;
    localparam logic [OPC_W-1:0] OP_SEL    = 7'h41;
    localparam logic [OPC_W-1:0] OP_SELATN = 7'h42;

    // strobe bit positions
    typedef enum int {
        S_NOP = 0, S_FLUSH = 1, S_RESET = 2, S_XFER = 3,
        S_CMPL = 4, S_SEL = 5, S_SELATN = 6
    } stb_idx_e;
    localparam int NUM_OPS = 7;

    localparam int                TC_BIT    = 4;
    localparam logic [DATA_W-1:0] INTR_DONE = 8'h08;
    localparam logic [DATA_W-1:0] CFG_RST   = 8'h07;
endpackage

// File: rtl/xcf_count_regs.sv
// Written and working copies of the transfer count, plus the
// "high byte written" flag. Assumes CNT_W is a multiple of 8.
module xcf_count_regs #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W/8-1:0] byte_we,
    input  logic [7:0]       wdata,
    input  logic             reload,
    output logic [CNT_W-1:0] wr_cnt,
    output logic [CNT_W-1:0] wk_cnt,
    output logic             hi_written
);
    localparam int NB = CNT_W / 8;

    genvar i;
    generate
        for (i = 0; i < NB; i++) begin : g_byte
            // write copy of one count byte
            always_ff @(posedge clk) begin
                if (!rst_n || clr)   wr_cnt[i*8 +: 8] <= '0;
                else if (byte_we[i]) wr_cnt[i*8 +: 8] <= wdata;
            end
        end
    endgenerate

    // working copy, loaded from the write copy on a DMA command
    always_ff @(posedge clk) begin
        if (!rst_n || clr) wk_cnt <= '0;
        else if (reload)   wk_cnt <= wr_cnt;
    end

    // remembers the first write of the top count byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        hi_written <= 1'b0;
        else if (byte_we[NB-1])   hi_written <= 1'b1;
    end
endmodule

// File: rtl/xcf_cmd_decode.sv
// Decodes the opcode field into a one-hot vector and registers it as
// one-cycle strobes. Only the power-on reset clears the strobes, so
// a reset command still shows its own strobe.
module xcf_cmd_decode
    import xfer_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [OPC_W-1:0] opcode,
    output logic [NUM_OPS-1:0] dec,
    output logic [NUM_OPS-1:0] stb
);
    // combinational opcode match
    always_comb begin
        dec = '0;
        unique case (opcode)
            OP_NOP:    dec[S_NOP]    = 1'b1;
            OP_FLUSH:  dec[S_FLUSH]  = 1'b1;
            OP_RESET:  dec[S_RESET]  = 1'b1;
            OP_XFER:   dec[S_XFER]   = 1'b1;
            OP_CMPL:   dec[S_CMPL]   = 1'b1;
            OP_SEL:    dec[S_SEL]    = 1'b1;
            OP_SELATN: dec[S_SELATN] = 1'b1;
            default:   dec = '0;
        endcase
    end

    // strobe register, one cycle per command write
    always_ff @(posedge clk) begin
        if (!rst_n)      stb <= '0;
        else if (cmd_we) stb <= dec;
        else             stb <= '0;
    end
endmodule

// File: rtl/xcf_len_calc.sv
// Effective transfer length: min(count, limit). A count of zero
// means 65536. The limit is the magnitude of the signed pending size,
// or CMD_BUF while a command is being collected. Purely combinational.
module xcf_len_calc #(
    parameter int CNT_W   = 24,
    parameter int PEND_W  = 25,
    parameter int CMD_BUF = 32
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PEND_W-1:0] pend,
    input  logic              collect,
    output logic [CNT_W-1:0]  len
);
    localparam int CW = (PEND_W > CNT_W + 1) ? PEND_W : CNT_W + 1;

    logic [CW-1:0] cnt_eff, mag, lim, res;

    // zero count stands for 65536; the sign of pend selects negation
    always_comb begin
        cnt_eff = (cnt == '0) ? CW'(32'h10000) : CW'(cnt);
        mag     = pend[PEND_W-1] ? CW'(~pend + 1'b1) : CW'(pend);
        lim     = collect ? CW'(CMD_BUF) : mag;
        res     = (cnt_eff < lim) ? cnt_eff : lim;
        len     = res[CNT_W-1:0];
    end
endmodule

// File: rtl/xfer_cmd_front.sv
// Top of the transfer count / command front end. Holds status, event
// and configuration registers, drives the read mux, and applies the
// reset command as a synchronous clear of all register state.
module xfer_cmd_front
    import xfer_cmd_pkg::*;
#(
    parameter int         ADDR_W  = 4,
    parameter int         CNT_W   = 24,
    parameter int         PEND_W  = 25,
    parameter int         CMD_BUF = 32,
    parameter logic [7:0] CHIP_ID = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [PEND_W-1:0]  pend_size,
    input  logic               cmd_collect,
    input  logic               tc_set,
    input  logic               ev_load,
    input  logic [7:0]         ev_intr,
    input  logic [7:0]         ev_seq,
    input  logic [7:0]         ev_flags,
    output logic               dma_mode,
    output logic [CNT_W-1:0]   xfer_len,
    output logic [NUM_OPS-1:0] op_stb
);
    localparam int NB = CNT_W / 8;

    logic [NB-1:0]      byte_we;
    logic [NUM_OPS-1:0] dec;
    logic [CNT_W-1:0]   wr_cnt, wk_cnt, src_cnt, len_c;
    logic               hi_wr_q, tc_q, wr_cmd, clr, reload, cnt_we;
    logic [7:0]         intr_q, seq_q, flags_q, cfg1_q, cmd_q;

    assign wr_cmd = wr_en && (addr == ADDR_W'(A_CMD));
    assign clr    = wr_cmd && dec[S_RESET];
    assign reload = wr_cmd && wdata[7] && !dec[S_RESET];
    assign cnt_we = |byte_we;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_we
            assign byte_we[b] = wr_en && (addr == ADDR_W'(b));
        end
    endgenerate

    xcf_count_regs #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .byte_we(byte_we),
        .wdata(wdata), .reload(reload), .wr_cnt(wr_cnt),
        .wk_cnt(wk_cnt), .hi_written(hi_wr_q)
    );

    xcf_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_we(wr_cmd),
        .opcode(wdata[OPC_W-1:0]), .dec(dec), .stb(op_stb)
    );

    // the count seen by a transfer command includes a same-write reload
    assign src_cnt = wdata[7] ? wr_cnt : wk_cnt;

    xcf_len_calc #(.CNT_W(CNT_W), .PEND_W(PEND_W), .CMD_BUF(CMD_BUF)) u_len (
        .cnt(src_cnt), .pend(pend_size), .collect(cmd_collect), .len(len_c)
    );

    // DMA mode follows bit 7 of each command byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr) dma_mode <= 1'b0;
        else if (wr_cmd)   dma_mode <= wdata[7];
    end

    // terminal-count bit: clears win over the set request
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                               tc_q <= 1'b0;
        else if (cnt_we || (wr_cmd && dec[S_XFER] && wdata[7])) tc_q <= 1'b0;
        else if (tc_set)                                 tc_q <= 1'b1;
    end

    // interrupt reason, sequence step and FIFO flags
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            intr_q  <= '0;
            seq_q   <= '0;
            flags_q <= '0;
        end else if (wr_cmd && dec[S_FLUSH]) begin
            intr_q  <= INTR_DONE;
            seq_q   <= '0;
            flags_q <= '0;
        end else if (ev_load) begin
            intr_q  <= ev_intr;
            seq_q   <= ev_seq;
            flags_q <= ev_flags;
        end
    end

    // configuration register with its non-zero default
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                            cfg1_q <= CFG_RST;
        else if (wr_en && addr == ADDR_W'(A_CFG))     cfg1_q <= wdata;
    end

    // last command byte, for readback
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cmd_q <= '0;
        else if (wr_cmd)   cmd_q <= wdata;
    end

    // effective length, captured on a transfer-information command
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              xfer_len <= '0;
        else if (wr_cmd && dec[S_XFER]) xfer_len <= len_c;
    end

    // read mux; the top count byte shows the chip ID until written
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_CNT_LO): rdata = wk_cnt[7:0];
            ADDR_W'(A_CNT_MD): rdata = wk_cnt[15:8];
            ADDR_W'(A_CNT_HI): rdata = hi_wr_q ? wk_cnt[CNT_W-1 -: 8] : CHIP_ID;
            ADDR_W'(A_CMD):    rdata = cmd_q;
            ADDR_W'(A_STAT):   rdata = 8'(tc_q) << TC_BIT;
            ADDR_W'(A_INTR):   rdata = intr_q;
            ADDR_W'(A_SEQ):    rdata = seq_q;
            ADDR_W'(A_FLAGS):  rdata = flags_q;
            ADDR_W'(A_CFG):    rdata = cfg1_q;
            default:           rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_cmd_front_chk.sv
// Property checker for xfer_cmd_front, attached with bind below.
module xfer_cmd_front_chk
    import xfer_cmd_pkg::*;
#(
    parameter int         ADDR_W  = 4,
    parameter logic [7:0] CHIP_ID = 8'h5A
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [7:0]         wdata,
    input logic [7:0]         rdata,
    input logic               dma_mode,
    input logic [NUM_OPS-1:0] op_stb,
    input logic               tc_q,
    input logic               hi_wr_q,
    input logic [7:0]         cfg1_q,
    input logic [7:0]         intr_q,
    input logic [7:0]         seq_q,
    input logic [7:0]         flags_q
);
    logic cmd_w;
    assign cmd_w = wr_en && (addr == ADDR_W'(A_CMD));

    AST_DMA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[6:0] != OP_RESET) |=> (dma_mode == $past(wdata[7]))); // R3
    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < ADDR_W'(A_CMD)) |=> !tc_q); // R4
    AST_CHIP_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_wr_q && addr == ADDR_W'(A_CNT_HI)) |-> (rdata == CHIP_ID)); // R8
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[6:0] == OP_RESET) |=> (cfg1_q == CFG_RST && !dma_mode && !hi_wr_q)); // R9
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[6:0] == OP_FLUSH) |=> (intr_q == INTR_DONE && seq_q == 8'd0 && flags_q == 8'd0)); // R10
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_stb)); // R11
    AST_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_w |=> (op_stb == '0)); // R11
endmodule

bind xfer_cmd_front xfer_cmd_front_chk #(.ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_chk (.*);

// File: tb/xfer_cmd_front_bench.sv
module xfer_cmd_front_bench;
    localparam logic [7:0] CHIP = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [24:0] pend_size = '0;
    logic        cmd_collect = 1'b0;
    logic        tc_set = 1'b0;
    logic        ev_load = 1'b0;
    logic [7:0]  ev_intr = '0, ev_seq = '0, ev_flags = '0;
    logic        dma_mode;
    logic [23:0] xfer_len;
    logic [6:0]  op_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xfer_cmd_front u_xfer_cmd_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pend_size(pend_size), .cmd_collect(cmd_collect),
        .tc_set(tc_set), .ev_load(ev_load), .ev_intr(ev_intr), .ev_seq(ev_seq),
        .ev_flags(ev_flags), .dma_mode(dma_mode), .xfer_len(xfer_len), .op_stb(op_stb)
    );

    task automatic check(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_tc(input bit with_cnt_write);
        @(negedge clk);
        tc_set = 1'b1;
        if (with_cnt_write) begin wr_en = 1'b1; addr = 4'd0; wdata = 8'h00; end
        @(negedge clk);
        tc_set = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_cnt(input int c);
        wr(4'd0, 8'(c)); wr(4'd1, 8'(c >> 8)); wr(4'd2, 8'(c >> 16));
    endtask

    function automatic longint exp_len(input longint c, input longint p, input bit col);
        longint ce, m;
        ce = (c == 0) ? 65536 : c;
        m = (p < 0) ? -p : p;
        if (col) m = 32;
        return (ce < m) ? ce : m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int cnts[8] = '{0, 1, 255, 256, 65535, 65536, 65537, 24'hFFFFFF};
        int pends[8] = '{0, 1, -1, 5, -65536, 65536, -200000, 100000};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, d); check("R1 cnt lo", d, 0);
        rd(4'd1, d); check("R1 cnt mid", d, 0);
        rd(4'd2, d); check("R1 chip id", d, CHIP);
        rd(4'd8, d); check("R1 cfg", d, 7);
        rd(4'd4, d); check("R1 status", d, 0);
        rd(4'd5, d); check("R1 intr", d, 0);
        check("R1 dma", dma_mode, 0);
        check("R1 stb", op_stb, 0);

        // R2 write copies stay hidden until reload; R8 chip id gone after write
        set_cnt(24'h001234);
        rd(4'd0, d); check("R2 no reload", d, 0);
        rd(4'd2, d); check("R8 hi written", d, 0);
        wr(4'd3, 8'h80);
        check("R11 nop stb", op_stb, 7'b0000001);
        check("R3 dma on", dma_mode, 1);
        rd(4'd0, d); check("R2 reload lo", d, 8'h34);
        rd(4'd1, d); check("R2 reload mid", d, 8'h12);
        wr(4'd3, 8'h00);
        check("R3 dma off", dma_mode, 0);
        wr(4'd0, 8'h77);
        rd(4'd0, d); check("R2 kept", d, 8'h34);

        // R4 terminal count
        pulse_tc(0);
        rd(4'd4, d); check("R4 tc set", d, 8'h10);
        wr(4'd1, 8'h00);
        rd(4'd4, d); check("R4 tc cleared", d, 0);
        pulse_tc(1);
        rd(4'd4, d); check("R4 clear wins", d, 0);

        // R7 transfer command and TC
        pulse_tc(0);
        wr(4'd3, 8'h10);
        rd(4'd4, d); check("R7 no dma keeps tc", d, 8'h10);
        wr(4'd3, 8'h90);
        rd(4'd4, d); check("R7 dma clears tc", d, 0);

        // R5 / R6 length sweep
        for (int col = 0; col < 2; col++) begin
            cmd_collect = col[0];
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    pend_size = 25'(pends[j]);
                    set_cnt(cnts[i]);
                    wr(4'd3, 8'h90);
                    check("R11 xfer stb", op_stb, 7'b0001000);
                    check(col ? "R6 collect len" : "R5 dma len", xfer_len,
                          exp_len(cnts[i], pends[j], col[0]));
                    set_cnt(cnts[(i + 3) % 8]);
                    wr(4'd3, 8'h10);
                    check(col ? "R6 working len" : "R5 working len", xfer_len,
                          exp_len(cnts[i], pends[j], col[0]));
                end
            end
        end
        cmd_collect = 1'b0;

        // R11 other opcodes
        wr(4'd3, 8'h11); check("R11 cmpl", op_stb, 7'b0010000);
        wr(4'd3, 8'h41); check("R11 sel", op_stb, 7'b0100000);
        wr(4'd3, 8'h42); check("R11 selatn", op_stb, 7'b1000000);

        // R12 event load, R11 unknown opcode, R10 flush
        @(negedge clk);
        ev_load = 1'b1; ev_intr = 8'hC3; ev_seq = 8'h05; ev_flags = 8'h09;
        @(negedge clk);
        ev_load = 1'b0;
        rd(4'd5, d); check("R12 intr", d, 8'hC3);
        rd(4'd6, d); check("R12 seq", d, 8'h05);
        rd(4'd7, d); check("R12 flags", d, 8'h09);
        pend_size = 25'd3;
        wr(4'd3, 8'h7F);
        check("R11 unknown stb", op_stb, 0);
        check("R11 unknown len", xfer_len, exp_len(cnts[7], pends[7], 1));
        rd(4'd5, d); check("R11 unknown intr", d, 8'hC3);
        wr(4'd3, 8'h01);
        check("R11 flush stb", op_stb, 7'b0000010);
        rd(4'd5, d); check("R10 intr", d, 8'h08);
        rd(4'd6, d); check("R10 seq", d, 0);
        rd(4'd7, d); check("R10 flags", d, 0);

        // R9 reset command
        wr(4'd8, 8'h33);
        rd(4'd8, d); check("R9 cfg written", d, 8'h33);
        wr(4'd3, 8'h80);
        wr(4'd3, 8'h82);
        check("R11 reset stb", op_stb, 7'b0000100);
        check("R9 dma", dma_mode, 0);
        check("R9 len", xfer_len, 0);
        rd(4'd8, d); check("R9 cfg", d, 7);
        rd(4'd0, d); check("R9 cnt", d, 0);
        rd(4'd2, d); check("R8 chip id back", d, CHIP);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule